// File: doc/BRIEF.md
# Graphic LCD Host Bus Interface

This block is the host side of a 64-column dot-matrix LCD column driver. A host processor talks to it over a strobed 8-bit parallel bus. Three chip selects, a data/instruction line, a read/write line and an enable strobe frame each transfer. The block samples the strobe into its own clock domain. It decodes instruction bytes into a page register, a column address counter, a first-displayed-row register and a display enable flag. It also moves bytes between the bus and a 512-byte display memory, organised as 8 pages of 64 bytes. The display scanner reads that memory through a separate read port.

The bus is split into an input byte, an output byte and an output enable, so the pad ring outside the block forms the bidirectional pins. Reads of memory go through an output holding register. The first data read after an address change therefore returns stale data, and the host must issue a discard read first.

A state machine paces every access. It has five states:

- `ST_IDLE` waits for a synchronized strobe rise and then moves to `ST_STROBE`.
- `ST_STROBE` waits for the synchronized strobe fall and then moves to `ST_EXEC`.
- `ST_EXEC` performs the captured access for one clock. After a selected write it moves to `ST_BUSY1`. After anything else it returns to `ST_IDLE`.
- `ST_BUSY1` always moves to `ST_BUSY2`.
- `ST_BUSY2` always returns to `ST_IDLE`.

A strobe that rises while the machine is not in `ST_IDLE` is not executed.

Top module: `glcd_host_if`

## Requirements
- R1: An access takes effect only when `sel_a_n_i`=0, `sel_b_n_i`=0 and `sel_c_i`=1. Any other select pattern changes no register and no memory byte, and the bus output enable stays 0.
- R2: The select lines decode as follows:
  - `dsel_i`=0, `rdn_i`=0: instruction write.
  - `dsel_i`=0, `rdn_i`=1: status read.
  - `dsel_i`=1, `rdn_i`=0: memory write.
  - `dsel_i`=1, `rdn_i`=1: memory read.
  
  Write bytes are taken at the falling edge of `stb_i`.
- R3: `bus_oe_o` is 1 only while `stb_i` is high during a selected read. At all other times it is 0.
- R4: Instruction `0011111x` sets `show_o` to bit 0 of the byte. Memory contents are not altered.
- R5: The following instructions load the registers:
  - `01cccccc` loads the 6-bit column address.
  - `10111ppp` loads the 3-bit page register.
  - `11tttttt` loads `top_row_o`.
  
  The page register changes only through its instruction.
- R6: Each memory write stores the byte at (page, column). Each memory write and each memory read then advances the column by 1, wrapping from 63 to 0 with the page unchanged.
- R7: A memory read drives the current holding register. The holding register is then reloaded from (page, column). The first read after an address change therefore returns the previous holding value.
- R8: The status byte has the following bits:
  - Bit 7: 1 while busy.
  - Bit 5: 1 while the display is off.
  - Bit 4: 1 while `rst_n_i` is low.
  - All other bits: 0.
  
  A status read needs no discard read.
- R9: While `rst_n_i` is low, the following hold:
  - `show_o`, `top_row_o`, the page, the column and the holding register are 0.
  - Writes and memory reads are ignored.
  - Only status reads drive the bus.
- R10: Busy (status bit 7) is high for exactly 2 clocks after each accepted write. It is never high after a read.
- R11: Instruction bytes that match none of the four patterns have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sel_a_n_i | input | 1 | Chip select, active low |
| sel_b_n_i | input | 1 | Chip select, active low |
| sel_c_i | input | 1 | Chip select, active high |
| dsel_i | input | 1 | 1 selects memory data, 0 selects instruction/status |
| rdn_i | input | 1 | 1 read, 0 write |
| stb_i | input | 1 | Enable strobe from host |
| bus_i | input | 8 | Bus byte from host |
| bus_o | output | 8 | Bus byte to host |
| bus_oe_o | output | 1 | Drive enable for the bus pads |
| scan_page_i | input | 3 | Scanner read page |
| scan_col_i | input | 6 | Scanner read column |
| scan_data_o | output | 8 | Scanner read byte |
| show_o | output | 1 | Display enable flag |
| top_row_o | output | 6 | First displayed row |

## Verification
The hardest situation to reach is the busy window. It lasts only two internal clocks and ends long before a normal host strobe could complete a status read. The bench handles this by ending a write strobe and then, two clocks later, raising a status read. It holds that read open while sampling bit 7 on every clock, which counts the busy width directly. The same probe after a memory read shows that reads do not raise busy. Column wrap and the stale first read are reached by directed address loads at column 63 and just after an address change. These are mixed with a long seeded random run checked against a bench-side model.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STROBE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_BUSY1  = 3'd3,
        ST_BUSY2  = 3'd4
    } hif_state_t;

    typedef struct packed {
        logic             sel;
        logic             dsel;
        logic             rdn;
        logic [BUS_W-1:0] data;
    } hif_access_t;
endpackage

// File: rtl/glcd_strobe_sync.sv
module glcd_strobe_sync
    import glcd_pkg::*;
#(
    parameter int SYNC_STAGES = 3
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             stb_i,
    input  logic             sel_i,
    input  logic             dsel_i,
    input  logic             rdn_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             rise_o,
    output logic             fall_o,
    output hif_access_t      acc_o
);
    logic [SYNC_STAGES-1:0] pipe_q;
    hif_access_t            acc_q;
    logic                   s_late;
    logic                   s_last;

    assign s_late = pipe_q[SYNC_STAGES-2];
    assign s_last = pipe_q[SYNC_STAGES-1];

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            pipe_q <= '0;
            acc_q  <= '0;
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-2:0], stb_i};
            // keep a snapshot of the bus lines while the strobe is seen high
            if (s_late) begin
                acc_q <= '{sel: sel_i, dsel: dsel_i, rdn: rdn_i, data: bus_i};
            end
        end
    end

    assign rise_o = s_late & ~s_last;
    assign fall_o = s_last & ~s_late;
    assign acc_o  = acc_q;
endmodule

// File: rtl/glcd_dram.sv
module glcd_dram #(
    parameter int PAGES = 8,
    parameter int COLS  = 64,
    parameter int W     = 8,
    localparam int PAW  = $clog2(PAGES),
    localparam int CAW  = $clog2(COLS),
    localparam int DEPTH = PAGES * COLS
) (
    input  logic           clk_i,
    input  logic           we_i,
    input  logic [PAW-1:0] wpage_i,
    input  logic [CAW-1:0] wcol_i,
    input  logic [W-1:0]   wdata_i,
    input  logic [PAW-1:0] rpage_a_i,
    input  logic [CAW-1:0] rcol_a_i,
    output logic [W-1:0]   rdata_a_o,
    input  logic [PAW-1:0] rpage_b_i,
    input  logic [CAW-1:0] rcol_b_i,
    output logic [W-1:0]   rdata_b_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[{wpage_i, wcol_i}] <= wdata_i;
        end
    end

    assign rdata_a_o = mem_q[{rpage_a_i, rcol_a_i}];
    assign rdata_b_o = mem_q[{rpage_b_i, rcol_b_i}];
endmodule

// File: rtl/glcd_cmd_fsm.sv
module glcd_cmd_fsm
    import glcd_pkg::*;
#(
    parameter int COLS  = 64,
    parameter int PAGES = 8,
    parameter int ROWS  = 64,
    localparam int CAW  = $clog2(COLS),
    localparam int PAW  = $clog2(PAGES),
    localparam int RAW  = $clog2(ROWS)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  hif_access_t      acc_i,
    input  logic [BUS_W-1:0] ram_rdata_i,
    output logic             ram_we_o,
    output logic [BUS_W-1:0] ram_wdata_o,
    output logic [PAW-1:0]   page_o,
    output logic [CAW-1:0]   col_o,
    output logic             show_o,
    output logic [RAW-1:0]   top_row_o,
    output logic [BUS_W-1:0] hold_o,
    output logic             busy_o,
    output hif_state_t       state_o
);
    hif_state_t           st_q, st_d;
    logic                 exec_w, do_cmd, do_wr, do_rd;
    logic [PAW-1:0]       page_q;
    logic [CAW-1:0]       col_q;
    logic                 show_q;
    logic [RAW-1:0]       top_q;
    logic [BUS_W-1:0]     hold_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= ST_IDLE;
        else          st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (rise_i) st_d = ST_STROBE;
            ST_STROBE: if (fall_i) st_d = ST_EXEC;
            ST_EXEC:   st_d = (acc_i.sel && !acc_i.rdn) ? ST_BUSY1 : ST_IDLE;
            ST_BUSY1:  st_d = ST_BUSY2;
            ST_BUSY2:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        exec_w = (st_q == ST_EXEC) && acc_i.sel;
        do_cmd = exec_w && !acc_i.dsel && !acc_i.rdn;
        do_wr  = exec_w &&  acc_i.dsel && !acc_i.rdn;
        do_rd  = exec_w &&  acc_i.dsel &&  acc_i.rdn;
        busy_o = (st_q == ST_BUSY1) || (st_q == ST_BUSY2);
    end

    // register file
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            page_q <= '0;
            col_q  <= '0;
            show_q <= 1'b0;
            top_q  <= '0;
            hold_q <= '0;
        end else begin
            if (do_cmd) begin
                casez (acc_i.data)
                    8'b0011111?: show_q <= acc_i.data[0];
                    8'b01??????: col_q  <= acc_i.data[CAW-1:0];
                    8'b10111???: page_q <= acc_i.data[PAW-1:0];
                    8'b11??????: top_q  <= acc_i.data[RAW-1:0];
                    default: ;
                endcase
            end
            if (do_wr || do_rd) begin
                col_q <= (col_q == CAW'(COLS - 1)) ? '0 : col_q + CAW'(1);
            end
            if (do_rd) begin
                hold_q <= ram_rdata_i;
            end
        end
    end

    assign ram_we_o    = do_wr;
    assign ram_wdata_o = acc_i.data;
    assign page_o      = page_q;
    assign col_o       = col_q;
    assign show_o      = show_q;
    assign top_row_o   = top_q;
    assign hold_o      = hold_q;
    assign state_o     = st_q;
endmodule

// File: rtl/glcd_host_if.sv
module glcd_host_if
    import glcd_pkg::*;
#(
    parameter int COLS        = 64,
    parameter int PAGES       = 8,
    parameter int ROWS        = 64,
    parameter int SYNC_STAGES = 3,
    localparam int CAW        = $clog2(COLS),
    localparam int PAW        = $clog2(PAGES),
    localparam int RAW        = $clog2(ROWS)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             sel_a_n_i,
    input  logic             sel_b_n_i,
    input  logic             sel_c_i,
    input  logic             dsel_i,
    input  logic             rdn_i,
    input  logic             stb_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic [BUS_W-1:0] bus_o,
    output logic             bus_oe_o,
    input  logic [PAW-1:0]   scan_page_i,
    input  logic [CAW-1:0]   scan_col_i,
    output logic [BUS_W-1:0] scan_data_o,
    output logic             show_o,
    output logic [RAW-1:0]   top_row_o
);
    logic             sel_w;
    logic             rise_w, fall_w;
    hif_access_t      acc_w;
    logic             we_w;
    logic [BUS_W-1:0] wdata_w, rdata_w, hold_w, status_w;
    logic [PAW-1:0]   page_w;
    logic [CAW-1:0]   col_w;
    logic             busy_w;
    hif_state_t       st_w;

    assign sel_w = ~sel_a_n_i & ~sel_b_n_i & sel_c_i;

    glcd_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .stb_i(stb_i), .sel_i(sel_w),
        .dsel_i(dsel_i), .rdn_i(rdn_i), .bus_i(bus_i),
        .rise_o(rise_w), .fall_o(fall_w), .acc_o(acc_w)
    );

    glcd_cmd_fsm #(.COLS(COLS), .PAGES(PAGES), .ROWS(ROWS)) fsm_i (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .rise_i(rise_w), .fall_i(fall_w),
        .acc_i(acc_w), .ram_rdata_i(rdata_w), .ram_we_o(we_w),
        .ram_wdata_o(wdata_w), .page_o(page_w), .col_o(col_w),
        .show_o(show_o), .top_row_o(top_row_o), .hold_o(hold_w),
        .busy_o(busy_w), .state_o(st_w)
    );

    glcd_dram #(.PAGES(PAGES), .COLS(COLS), .W(BUS_W)) ram_i (
        .clk_i(clk_i), .we_i(we_w), .wpage_i(page_w), .wcol_i(col_w),
        .wdata_i(wdata_w), .rpage_a_i(page_w), .rcol_a_i(col_w),
        .rdata_a_o(rdata_w), .rpage_b_i(scan_page_i), .rcol_b_i(scan_col_i),
        .rdata_b_o(scan_data_o)
    );

    assign status_w = {busy_w, 1'b0, ~show_o, ~rst_n_i, 4'b0000};
    assign bus_o    = dsel_i ? hold_w : status_w;
    assign bus_oe_o = stb_i & sel_w & rdn_i & (~dsel_i | rst_n_i);
endmodule

// File: rtl/glcd_host_if_chk.sv
module glcd_host_if_chk
    import glcd_pkg::*;
#(
    parameter int CAW = 6,
    parameter int PAW = 3,
    parameter int RAW = 6
) (
    input logic           clk_i,
    input logic           rst_n_i,
    input logic           stb_i,
    input logic           sel_a_n_i,
    input logic           sel_b_n_i,
    input logic           sel_c_i,
    input logic           rdn_i,
    input logic           bus_oe_o,
    input logic           busy_w,
    input hif_state_t     st_w,
    input logic [PAW-1:0] page_w,
    input logic [CAW-1:0] col_w,
    input logic           show_o,
    input logic [RAW-1:0] top_row_o
);
    logic sel_ok;
    assign sel_ok = !sel_a_n_i && !sel_b_n_i && sel_c_i;

    AST_BUS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(stb_i && sel_ok && rdn_i) |-> !bus_oe_o); // R3

    AST_BUSY_TWO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(busy_w) |=> busy_w ##1 !busy_w); // R10

    AST_PAGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_w != ST_EXEC) |=> $stable(page_w)); // R5

    AST_COL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_w != ST_EXEC) |=> $stable(col_w)); // R6

    always @(posedge clk_i) begin
        if (!rst_n_i) begin
            AST_RESET_CLEAR: assert (!show_o && top_row_o == '0); // R9
        end
    end
endmodule

bind glcd_host_if glcd_host_if_chk #(.CAW(CAW), .PAW(PAW), .RAW(RAW)) chk_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .stb_i(stb_i), .sel_a_n_i(sel_a_n_i),
    .sel_b_n_i(sel_b_n_i), .sel_c_i(sel_c_i), .rdn_i(rdn_i),
    .bus_oe_o(bus_oe_o), .busy_w(busy_w), .st_w(st_w), .page_w(page_w),
    .col_w(col_w), .show_o(show_o), .top_row_o(top_row_o)
);

// File: tb/glcd_host_if_tb_top.sv
module glcd_host_if_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, sa_n, sb_n, sc, dsel, rdn, stb, oe, show;
    logic [7:0] bus_in, bus_out, scan_data;
    logic [2:0] scan_page;
    logic [5:0] scan_col, top_row;

    glcd_host_if dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .sel_a_n_i(sa_n), .sel_b_n_i(sb_n),
        .sel_c_i(sc), .dsel_i(dsel), .rdn_i(rdn), .stb_i(stb), .bus_i(bus_in),
        .bus_o(bus_out), .bus_oe_o(oe), .scan_page_i(scan_page),
        .scan_col_i(scan_col), .scan_data_o(scan_data), .show_o(show),
        .top_row_o(top_row)
    );

    int  n_run = 0, n_fail = 0;
    bit  finished = 0;

    logic [7:0] m_ram [8][64];
    logic [2:0] m_page;
    logic [5:0] m_col, m_top;
    logic       m_show;
    logic [7:0] m_hold;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {1'b0, 1'b0, ~m_show, ~rst_n, 4'b0000};
    endfunction

    task automatic model_reset();
        m_page = 0; m_col = 0; m_top = 0; m_show = 0; m_hold = 0;
    endtask

    task automatic model_step(input bit ok, input logic ds, input logic rd, input logic [7:0] b);
        if (!ok || !rst_n) return;
        if (!ds && !rd) begin
            if (b[7:1] == 7'b0011111)      m_show = b[0];
            else if (b[7:6] == 2'b01)      m_col  = b[5:0];
            else if (b[7:3] == 5'b10111)   m_page = b[2:0];
            else if (b[7:6] == 2'b11)      m_top  = b[5:0];
        end else if (ds && !rd) begin
            m_ram[m_page][m_col] = b;
            m_col = m_col + 6'd1;
        end else if (ds && rd) begin
            m_hold = m_ram[m_page][m_col];
            m_col  = m_col + 6'd1;
        end
    endtask

    task automatic set_sel(input bit ok);
        if (ok) {sa_n, sb_n, sc} = 3'b001;
        else case ($urandom_range(0, 2))
            0: {sa_n, sb_n, sc} = 3'b101;
            1: {sa_n, sb_n, sc} = 3'b011;
            default: {sa_n, sb_n, sc} = 3'b000;
        endcase
    endtask

    task automatic access(input bit ok, input logic ds, input logic rd, input logic [7:0] b,
                          output logic [7:0] rv, output logic rv_oe);
        @(negedge clk);
        set_sel(ok); dsel = ds; rdn = rd; bus_in = b;
        repeat (2) @(negedge clk);
        stb = 1'b1;
        repeat (3) @(negedge clk);
        rv = bus_out; rv_oe = oe;
        stb = 1'b0;
        repeat (4) @(negedge clk);
        {sa_n, sb_n, sc} = 3'b110;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b);
        logic [7:0] rv; logic ro;
        access(1, 0, 0, b, rv, ro);
        model_step(1, 0, 0, b);
    endtask

    task automatic wr(input logic [7:0] b);
        logic [7:0] rv; logic ro;
        access(1, 1, 0, b, rv, ro);
        model_step(1, 1, 0, b);
    endtask

    task automatic rd_chk(input string tag);
        logic [7:0] rv; logic ro;
        access(1, 1, 1, 8'h00, rv, ro);
        check(tag, rv, m_hold);
        model_step(1, 1, 1, 8'h00);
    endtask

    task automatic stat_chk(input string tag);
        logic [7:0] rv; logic ro;
        access(1, 0, 1, 8'h00, rv, ro);
        check(tag, {ro, rv}, {1'b1, exp_status()});
    endtask

    task automatic scan_chk(input string tag, input logic [2:0] p, input logic [5:0] c);
        scan_page = p; scan_col = c;
        #1;
        check(tag, scan_data, m_ram[p][c]);
    endtask

    // finish a write (or read), then hold a status read open and count busy clocks
    task automatic busy_probe(input logic ds, input logic rd, input logic [7:0] b, output int cnt);
        @(negedge clk);
        set_sel(1); dsel = ds; rdn = rd; bus_in = b;
        repeat (2) @(negedge clk);
        stb = 1'b1;
        repeat (3) @(negedge clk);
        stb = 1'b0;
        repeat (2) @(negedge clk);
        dsel = 1'b0; rdn = 1'b1; stb = 1'b1;
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            if (oe && bus_out[7]) cnt++;
            @(negedge clk);
        end
        stb = 1'b0;
        {sa_n, sb_n, sc} = 3'b110;
        repeat (8) @(negedge clk);
        model_step(1, ds, rd, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv; logic ro; int cnt;
        void'($urandom(32'd20240611));
        rst_n = 1'b1; {sa_n, sb_n, sc} = 3'b110; dsel = 0; rdn = 0; stb = 0;
        bus_in = 0; scan_page = 0; scan_col = 0;
        #1 rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);

        // R9 / R8: reset state
        check("R9 show in reset", show, 1'b0);
        check("R9 top row in reset", top_row, 6'd0);
        stat_chk("R8 R9 status in reset");
        access(1, 0, 0, 8'h3F, rv, ro);
        check("R9 command ignored in reset", show, 1'b0);
        access(1, 1, 1, 8'h00, rv, ro);
        check("R9 memory read not driven in reset", ro, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        stat_chk("R8 status after reset");

        // fill memory, R2 R6
        for (int p = 0; p < 8; p++) begin
            cmd(8'hB8 | 8'(p));
            cmd(8'h40);
            for (int c = 0; c < 64; c++) wr(8'($urandom));
        end
        for (int k = 0; k < 12; k++)
            scan_chk("R2 R6 memory write", 3'($urandom), 6'($urandom));

        // R4 display on/off
        cmd(8'h3F);
        check("R4 show on", show, 1'b1);
        stat_chk("R4 R8 status on");
        cmd(8'h3E);
        check("R4 show off", show, 1'b0);
        scan_chk("R4 memory untouched", 3'd2, 6'd7);

        // R5 start line and addresses
        cmd(8'hC0 | 8'd37);
        check("R5 top row", top_row, 6'd37);

        // R7 stale first read
        cmd(8'hB8 | 8'd3); cmd(8'h40 | 8'd10);
        rd_chk("R7 discard read returns stale");
        rd_chk("R7 second read returns page3 col10");
        rd_chk("R7 R6 following read col11");

        // R6 wrap within page
        cmd(8'hB8 | 8'd5); cmd(8'h40 | 8'd63);
        wr(8'hAA); wr(8'h55);
        scan_chk("R6 byte at col63", 3'd5, 6'd63);
        scan_chk("R6 wrap to col0 same page", 3'd5, 6'd0);
        check("R6 wrapped data", m_ram[5][0], 8'h55);

        // R11 undefined codes
        cmd(8'h3F);
        cmd(8'h00); cmd(8'h20); cmd(8'h80); cmd(8'hB0); cmd(8'h3D);
        check("R11 show kept", show, 1'b1);
        check("R11 top row kept", top_row, 6'd37);
        wr(8'h5A);
        scan_chk("R11 page/col kept", 3'd5, 6'd1);

        // R1 deselected accesses
        access(0, 0, 0, 8'h3E, rv, ro);
        check("R1 deselected command ignored", show, 1'b1);
        access(0, 1, 0, 8'hC3, rv, ro);
        wr(8'h11);
        scan_chk("R1 deselected write ignored", 3'd5, 6'd2);
        access(0, 0, 1, 8'h00, rv, ro);
        check("R1 R3 deselected read not driven", ro, 1'b0);

        // R3 drive only with strobe high
        @(negedge clk); set_sel(1); dsel = 0; rdn = 1;
        repeat (2) @(negedge clk);
        check("R3 no drive with strobe low", oe, 1'b0);
        stb = 1'b1; #1;
        check("R3 drive with strobe high", oe, 1'b1);
        @(negedge clk) stb = 1'b0; #1;
        check("R3 release after strobe", oe, 1'b0);
        {sa_n, sb_n, sc} = 3'b110;
        repeat (8) @(negedge clk);

        // R10 busy width
        busy_probe(1, 0, 8'h99, cnt);
        check("R10 busy after data write", cnt, 2);
        busy_probe(0, 0, 8'hC5, cnt);
        check("R10 busy after command", cnt, 2);
        busy_probe(1, 1, 8'h00, cnt);
        check("R10 no busy after read", cnt, 0);

        // seeded random run
        for (int i = 0; i < 300; i++) begin
            case ($urandom_range(0, 5))
                0: case ($urandom_range(0, 4))
                       0: cmd(8'h3E | 8'($urandom_range(0, 1)));
                       1: cmd(8'h40 | 8'($urandom_range(0, 63)));
                       2: cmd(8'hB8 | 8'($urandom_range(0, 7)));
                       3: cmd(8'hC0 | 8'($urandom_range(0, 63)));
                       default: cmd(8'($urandom));
                   endcase
                1: wr(8'($urandom));
                2: rd_chk("R7 random read");
                3: stat_chk("R8 random status");
                4: begin
                       access(0, 1'($urandom), 1'($urandom), 8'($urandom), rv, ro);
                       check("R1 random deselect no drive", ro, 1'b0);
                   end
                default: scan_chk("R6 random scan", 3'($urandom), 6'($urandom));
            endcase
            if (i == 150) begin
                // R9 mid-run reset
                @(negedge clk) rst_n = 1'b0;
                model_reset();
                stat_chk("R9 status in mid reset");
                access(1, 1, 0, 8'h77, rv, ro);
                check("R9 top row cleared", top_row, 6'd0);
                @(negedge clk) rst_n = 1'b1;
                repeat (2) @(negedge clk);
                scan_chk("R9 write ignored in reset", 3'd0, 6'd0);
            end
        end
        check("R4 final show", show, m_show);
        check("R5 final top row", top_row, m_top);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule